// File: doc/BRIEF.md
# Coherent Split-Read ADC Result Register Bank

This block holds the newest result of each of four free-running 10-bit auxiliary converters and lets a host read them over an 8-bit register read port. Every channel appears as two byte registers. The upper register gives the top eight bits of the result. The lower register gives the remaining two bits.

A host that needs all ten bits reads the upper register first. That read also copies the channel's two low bits into a per-channel shadow. A later read of the lower register returns the shadow. The two halves therefore come from one conversion, even if the converter has delivered newer results in between. A host that reads only the upper register treats the channel as an 8-bit converter.

Results arrive from the converter side on a per-channel valid strobe. They update the live value whatever the host is doing, and reads never hold up or disturb the converter side. Read data is registered: it appears in the cycle after the read strobe and stays unchanged until the next read.

Top module: `adcbank_top`

## Requirements
- R1: After reset every live result and every shadow is zero, so a read of any bank address returns 0x00.
- R2: A read of address 0x10+2k (channel k, 0 to 3) returns bits 9:2 of that channel's newest result. The value appears on the read data port in the cycle after the read strobe.
- R3: A read of address 0x11+2k returns the channel's shadow in bits 1:0, and bits 7:2 read as zero.
- R4: A read of the upper register copies bits 1:0 of that channel's current result into its shadow. A later read of the lower register returns those bits, even if newer results have arrived since.
- R5: Reads of the lower register never change the shadow. Without a new upper read, repeated lower reads return the same last-captured value.
- R6: A valid strobe on a channel replaces its live result whatever the read activity. Between read strobes the read data port holds its last value.
- R7: When a result update and an upper-register read of the same channel fall in the same cycle, the read returns the pre-update value and the shadow captures the pre-update low bits.
- R8: An upper-register read of one channel leaves the shadows of all other channels unchanged.
- R9: A read of any address outside 0x10 to 0x17 returns 0x00 and changes no shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| convValid | input | 4 | Per-channel new-result strobe |
| convData | input | 40 | Packed results; channel k occupies bits 10k+9 to 10k |
| rdEn | input | 1 | Single-cycle host read strobe |
| rdAddr | input | 8 | Host read byte address |
| rdData | output | 8 | Registered read data |

## Verification
The hardest case to reach from the ports is a shadow that has gone stale on purpose. An upper read must be followed by a fresh result on the same channel before the lower read, so that the live and shadowed low bits differ. The stimulus loads a value, reads the upper byte, loads a value with different low bits, and only then reads the lower register. The same-cycle collision is reached by raising the valid strobe and the read strobe on one falling edge. The result is then compared with the pre-update value on both halves.

// File: rtl/adcbank_pkg.sv
package adcbank_pkg;
  localparam int CH_N   = 4;
  localparam int RES_W  = 10;
  localparam int BUS_W  = 8;
  localparam int LO_W   = RES_W - BUS_W;
  localparam int ADDR_W = 8;

  typedef struct packed {
    logic            load;
    logic [CH_N-1:0] hiRd;
    logic [CH_N-1:0] loRd;
  } rdStrobe_t;
endpackage

// File: rtl/adcbank_ctrl.sv
module adcbank_ctrl
  import adcbank_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output rdStrobe_t         strb
);
  localparam int SPAN = 2 * CH_N;

  logic [ADDR_W-1:0] offset;
  logic              inRange;

  assign offset  = rdAddr - BASE_ADDR;
  assign inRange = (int'(rdAddr) >= int'(BASE_ADDR)) &&
                   (int'(rdAddr) <  int'(BASE_ADDR) + SPAN);

  assign strb.load = rdEn;

  for (genvar k = 0; k < CH_N; k++) begin : g_dec
    assign strb.hiRd[k] = rdEn && inRange && (int'(offset) == 2 * k);
    assign strb.loRd[k] = rdEn && inRange && (int'(offset) == 2 * k + 1);
  end

  // R9: at most one register is selected per read
  a_r9_single_select: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.hiRd, strb.loRd}));

  // R6: no select without a read strobe
  a_r6_no_idle_select: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> ({strb.hiRd, strb.loRd} == '0));
endmodule

// File: rtl/adcbank_dp.sv
module adcbank_dp
  import adcbank_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CH_N-1:0]       convValid,
  input  logic [CH_N*RES_W-1:0] convData,
  input  rdStrobe_t             strb,
  output logic [BUS_W-1:0]      rdData
);
  logic [RES_W-1:0] live [CH_N];
  logic [LO_W-1:0]  hold [CH_N];
  logic [BUS_W-1:0] rdNext;

  for (genvar k = 0; k < CH_N; k++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        live[k] <= '0;
      end else if (convValid[k]) begin
        live[k] <= convData[k*RES_W +: RES_W];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hold[k] <= '0;
      end else if (strb.hiRd[k]) begin
        hold[k] <= live[k][LO_W-1:0];
      end
    end

    // R6: a valid strobe loads the channel result
    a_r6_live_load: assert property (@(posedge clk) disable iff (!rstN)
      convValid[k] |=> (live[k] == $past(convData[k*RES_W +: RES_W])));

    // R4 / R7: an upper read captures the pre-edge low bits
    a_r4_capture: assert property (@(posedge clk) disable iff (!rstN)
      strb.hiRd[k] |=> (hold[k] == $past(live[k][LO_W-1:0])));

    // R5 / R8 / R9: shadow untouched unless its own upper read
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
      !strb.hiRd[k] |=> $stable(hold[k]));
  end

  always_comb begin
    rdNext = '0;
    for (int k = 0; k < CH_N; k++) begin
      if (strb.hiRd[k]) rdNext = rdNext | live[k][RES_W-1:LO_W];
      if (strb.loRd[k]) rdNext = rdNext | BUS_W'(hold[k]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.load) begin
      rdData <= rdNext;
    end
  end

  // R3: reserved bits of a lower read come back zero
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.loRd) |=> (rdData[BUS_W-1:LO_W] == '0));
endmodule

// File: rtl/adcbank_top.sv
module adcbank_top
  import adcbank_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CH_N-1:0]       convValid,
  input  logic [CH_N*RES_W-1:0] convData,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic [BUS_W-1:0]      rdData
);
  rdStrobe_t strb;

  adcbank_ctrl #(.BASE_ADDR(BASE_ADDR)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .rdEn   (rdEn),
    .rdAddr (rdAddr),
    .strb   (strb)
  );

  adcbank_dp dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .convValid (convValid),
    .convData  (convData),
    .strb      (strb),
    .rdData    (rdData)
  );

  // R9: an out-of-bank read returns zero
  a_r9_outside_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && ((int'(rdAddr) < int'(BASE_ADDR)) ||
              (int'(rdAddr) >= int'(BASE_ADDR) + 2 * CH_N))) |=> (rdData == '0));

  // R6: read data holds between read strobes
  a_r6_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));
endmodule

// File: tb/adcbank_top_tb_top.sv
module adcbank_top_tb_top;
  import adcbank_pkg::*;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic [CH_N-1:0]       convValid = '0;
  logic [CH_N*RES_W-1:0] convData = '0;
  logic                  rdEn = 1'b0;
  logic [ADDR_W-1:0]     rdAddr = '0;
  logic [BUS_W-1:0]      rdData;

  int nChk = 0;
  int nBad = 0;

  always #2 clk = ~clk;

  adcbank_top dut_i (
    .clk(clk), .rstN(rstN), .convValid(convValid), .convData(convData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] addr, output logic [7:0] val);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = addr;
    @(negedge clk);
    rdEn = 1'b0;
    val = rdData;
  endtask

  task automatic load(input int ch, input logic [9:0] v);
    @(negedge clk);
    convValid = '0; convValid[ch] = 1'b1;
    convData[ch*RES_W +: RES_W] = v;
    @(negedge clk);
    convValid = '0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 8'h10; a <= 8'h17; a++) begin
      rd(8'(a), v); chk("R1 reset read", v, 8'h00);
    end
  endtask

  task automatic t_map();
    logic [7:0] v;
    load(0, 10'h3A5); load(1, 10'h0FE); load(2, 10'h2C3); load(3, 10'h156);
    rd(8'h10, v); chk("R2 ch0 high", v, 8'hE9);
    rd(8'h12, v); chk("R2 ch1 high", v, 8'h3F);
    rd(8'h14, v); chk("R2 ch2 high", v, 8'hB0);
    rd(8'h16, v); chk("R2 ch3 high", v, 8'h55);
    rd(8'h11, v); chk("R3 ch0 low", v, 8'h01);
    rd(8'h13, v); chk("R3 ch1 low", v, 8'h02);
    rd(8'h15, v); chk("R3 ch2 low", v, 8'h03);
    rd(8'h17, v); chk("R3 ch3 low", v, 8'h02);
  endtask

  task automatic t_stale();
    logic [7:0] v;
    load(0, 10'h2A6);
    rd(8'h10, v); chk("R4 ch0 high", v, 8'hA9);
    load(0, 10'h1FD);
    rd(8'h11, v); chk("R4 low from captured conversion", v, 8'h02);
    rd(8'h11, v); chk("R5 repeat low", v, 8'h02);
    rd(8'h10, v); chk("R6 live updated under reads", v, 8'h7F);
    rd(8'h11, v); chk("R4 low after fresh high", v, 8'h01);
  endtask

  task automatic t_idleHold();
    logic [7:0] v;
    rd(8'h14, v);
    repeat (3) @(negedge clk);
    chk("R6 data holds while idle", rdData, 8'hB0);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    load(3, 10'h0C1);
    @(negedge clk);
    convValid = 4'b1000; convData[3*RES_W +: RES_W] = 10'h3FE;
    rdEn = 1'b1; rdAddr = 8'h16;
    @(negedge clk);
    convValid = '0; rdEn = 1'b0;
    chk("R7 collide high old", rdData, 8'h30);
    rd(8'h17, v); chk("R7 collide low old", v, 8'h01);
    rd(8'h16, v); chk("R7 new value now live", v, 8'hFF);
  endtask

  task automatic t_indep();
    logic [7:0] v;
    load(1, 10'h001);
    load(2, 10'h000);
    rd(8'h14, v); chk("R8 ch2 high", v, 8'h00);
    rd(8'h13, v); chk("R8 ch1 shadow kept", v, 8'h02);
    rd(8'h15, v); chk("R8 ch2 shadow new", v, 8'h00);
  endtask

  task automatic t_outside();
    logic [7:0] v;
    load(1, 10'h003);
    rd(8'h0F, v); chk("R9 addr 0x0F", v, 8'h00);
    rd(8'h18, v); chk("R9 addr 0x18", v, 8'h00);
    rd(8'h00, v); chk("R9 addr 0x00", v, 8'h00);
    rd(8'hFF, v); chk("R9 addr 0xFF", v, 8'h00);
    rd(8'h13, v); chk("R9 shadow untouched", v, 8'h02);
  endtask

  initial begin
    #400000;
    nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk + 1, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset output", rdData, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_stale();
    t_idleHold();
    t_collide();
    t_indep();
    t_outside();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule